// File: doc/BRIEF.md
# DS3 FEAC Receive Code Validator

This block sits behind the receive side of a DS3 framer running C-bit parity framing. Far-end alarm and control messages have already been found in the overhead and are handed over one at a time as a 6-bit code qualified by a one-cycle strobe. The block keeps a window of the ten most recent codes. A code becomes the held code once at least eight of those ten agree on it, and the held code is dropped once three of the ten disagree with it.

Software sees two byte-wide registers through a plain read/write port. The code register shows the held code. The control register carries a held-code flag, two interrupt enables and two sticky status bits, one for a new code and one for a dropped code; the status bits clear when that register is read. An interrupt line combines each status bit with its enable. When the channel leaves C-bit parity mode the block goes idle, forgets its history and clears its code and flags.

Top module: `feac_rx_validator`

## Requirements
- R1: Address 0 is the code register: the held code appears in bits 6 to 1, and bits 7 and 0 read as zero. Address 1 is the control register: bit 0 new-code status, bit 1 new-code enable, bit 2 drop status, bit 3 drop enable, bit 4 held-code flag, bits 7 to 5 zero. Read data follows reg_addr combinationally.
- R2: After reset with C-bit mode on, the code register reads 0x7E, the control register reads 0x00 and irq is low.
- R3: When no code is held and a strobe brings the count of one code among the last ten messages to eight or more, that code is loaded at the same clock edge, the held-code flag goes to 1 and the new-code status is set.
- R4: When a code is held and a strobe brings the count of messages among the last ten that differ from it to three or more, the code field is cleared to zero, the held-code flag goes to 0 and the drop status is set.
- R5: Seven matching messages do not validate a code, and two differing messages do not drop a held code.
- R6: While C-bit mode is off, the history is emptied and the code field, held-code flag and both status bits are cleared; the enables are kept. After C-bit mode returns, eight fresh messages are needed to validate.
- R7: The enables are read/write, reset to 0, and irq is high exactly when some status bit and its enable are both set.
- R8: A read of address 1 returns the current value and clears both status bits at that clock edge, except that a status bit set by an event at the same edge stays set.
- R9: Writes to address 0, and writes to the flag and status bits of address 1, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cbit_mode | input | 1 | Channel is in C-bit parity framing |
| msg_valid | input | 1 | One-cycle strobe for a received message |
| msg_code | input | 6 | Received message code |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | Register select: 0 code, 1 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case is a status bit being set by a message at the very edge where software reads and clears the control register. The bench builds a held code, feeds two disagreeing messages, then presents the third disagreeing message and the control read in the same cycle, checks that the read returns the old value and that the drop status survives. A second awkward case is the window sliding over old entries: after a drop, leftover codes in the history must keep the seventh new message from validating while the eighth does.

// File: rtl/feac_rx_validator.sv
module feac_rx_validator #(
  parameter int CODE_W     = 6,
  parameter int WIN        = 10,
  parameter int VALID_MIN  = 8,
  parameter int REMOVE_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cbit_mode,
  input  logic              msg_valid,
  input  logic [CODE_W-1:0] msg_code,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [CODE_W+1:0] reg_wdata,
  output logic [CODE_W+1:0] reg_rdata,
  output logic              irq
);
  localparam int CW = $clog2(WIN + 1);

  logic [CODE_W-1:0] hist [WIN];
  logic [WIN-1:0]    hvld;
  logic [CODE_W-1:0] held_code;
  logic              held_vld, st_v, st_r, en_v, en_r;
  logic [CW-1:0]     n_match, n_diff;
  logic              validate, remove, rd_ctrl;

  always_comb begin
    n_match = CW'(1);
    n_diff  = CW'(msg_code != held_code);
    for (int i = 0; i < WIN - 1; i++) begin
      if (hvld[i]) begin
        n_match = n_match + CW'(hist[i] == msg_code);
        n_diff  = n_diff + CW'(hist[i] != held_code);
      end
    end
  end

  assign validate = cbit_mode && msg_valid && !held_vld && n_match >= CW'(VALID_MIN);
  assign remove   = cbit_mode && msg_valid && held_vld && n_diff >= CW'(REMOVE_MIN);
  assign rd_ctrl  = reg_rd && reg_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) hist[i] <= '0;
      hvld      <= '0;
      held_code <= '1;
      held_vld  <= 1'b0;
      st_v      <= 1'b0;
      st_r      <= 1'b0;
      en_v      <= 1'b0;
      en_r      <= 1'b0;
    end else begin
      if (reg_wr && reg_addr) begin
        en_v <= reg_wdata[1];
        en_r <= reg_wdata[3];
      end
      if (!cbit_mode) begin
        hvld      <= '0;
        held_code <= '0;
        held_vld  <= 1'b0;
        st_v      <= 1'b0;
        st_r      <= 1'b0;
      end else begin
        if (msg_valid) begin
          hist[0] <= msg_code;
          for (int i = 1; i < WIN; i++) hist[i] <= hist[i-1];
          hvld <= {hvld[WIN-2:0], 1'b1};
        end
        if (validate) begin
          held_code <= msg_code;
          held_vld  <= 1'b1;
        end
        if (remove) begin
          held_code <= '0;
          held_vld  <= 1'b0;
        end
        st_v <= validate || (st_v && !rd_ctrl);
        st_r <= remove || (st_r && !rd_ctrl);
      end
    end
  end

  assign irq = (st_v && en_v) || (st_r && en_r);
  assign reg_rdata = reg_addr ? {{(CODE_W-3){1'b0}}, held_vld, en_r, st_r, en_v, st_v}
                              : {1'b0, held_code, 1'b0};
endmodule

// File: rtl/feac_rx_validator_chk.sv
module feac_rx_validator_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cbit_mode,
  input logic              msg_valid,
  input logic              reg_rd,
  input logic              reg_addr,
  input logic              irq,
  input logic [CODE_W-1:0] held_code,
  input logic              held_vld,
  input logic              st_v,
  input logic              st_r,
  input logic              en_v,
  input logic              en_r
);
  a_r6_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cbit_mode |=> (!held_vld && !st_v && !st_r));

  a_r4_drop_zeroes_code: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_vld) |-> held_code == '0);

  a_r3_rise_needs_msg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_vld) |-> ($past(msg_valid) && $past(cbit_mode)));

  a_r3_rise_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_vld) |-> st_v);

  a_r7_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_v && !en_r) |-> !irq);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr && !msg_valid) |=> (!st_v && !st_r));
endmodule

bind feac_rx_validator feac_rx_validator_chk #(.CODE_W(CODE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cbit_mode(cbit_mode), .msg_valid(msg_valid),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .irq(irq), .held_code(held_code),
  .held_vld(held_vld), .st_v(st_v), .st_r(st_r), .en_v(en_v), .en_r(en_r)
);

// File: tb/test_feac_rx_validator.sv
module test_feac_rx_validator;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, cbit_mode, msg_valid, reg_wr, reg_rd, reg_addr, irq;
  logic [5:0] msg_code;
  logic [7:0] reg_wdata, reg_rdata;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  feac_rx_validator i_feac_rx_validator (
    .clk(clk), .rst_n(rst_n), .cbit_mode(cbit_mode), .msg_valid(msg_valid),
    .msg_code(msg_code), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic send(input logic [5:0] c);
    @(negedge clk); msg_valid = 1'b1; msg_code = c;
    @(negedge clk); msg_valid = 1'b0;
  endtask

  task automatic send_n(input logic [5:0] c, input int n);
    for (int i = 0; i < n; i++) send(c);
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(1'b0, d); chk("R2 code reg reset", d, 8'h7E);
    rd(1'b1, d); chk("R2 ctrl reg reset", d, 8'h00);
    chk("R2 irq reset", {7'd0, irq}, 8'h00);
    wr(1'b1, 8'h0A);
    rd(1'b1, d); chk("R7 enables written", d, 8'h0A);
  endtask

  task automatic t_validate;
    logic [7:0] d;
    send_n(6'h05, 7);
    rd(1'b0, d); chk("R5 seven matches hold nothing", d, 8'h7E);
    chk("R5 irq low", {7'd0, irq}, 8'h00);
    send(6'h05);
    chk("R7 irq on new code", {7'd0, irq}, 8'h01);
    rd(1'b0, d); chk("R3 R1 code field", d, 8'h0A);
    rd(1'b1, d); chk("R3 ctrl after validate", d, 8'h1B);
    rd(1'b1, d); chk("R8 status cleared by read", d, 8'h1A);
    chk("R8 irq low after read", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_remove;
    logic [7:0] d;
    send(6'h11); send(6'h22);
    rd(1'b0, d); chk("R5 two differing keep code", d, 8'h0A);
    send(6'h33);
    chk("R7 irq on drop", {7'd0, irq}, 8'h01);
    rd(1'b0, d); chk("R4 code cleared", d, 8'h00);
    rd(1'b1, d); chk("R4 ctrl after drop", d, 8'h0E);
    rd(1'b1, d); chk("R8 drop status cleared", d, 8'h0A);
  endtask

  task automatic t_write_ignored;
    logic [7:0] d;
    wr(1'b0, 8'hFF);
    rd(1'b0, d); chk("R9 code reg not writable", d, 8'h00);
    wr(1'b1, 8'hF5);
    rd(1'b1, d); chk("R9 flag and status not writable", d, 8'h00);
    chk("R9 irq low", {7'd0, irq}, 8'h00);
    wr(1'b1, 8'h0A);
  endtask

  task automatic t_slide;
    logic [7:0] d;
    send_n(6'h2A, 7);
    rd(1'b0, d); chk("R3 old entries still in window", d, 8'h00);
    send(6'h2A);
    rd(1'b0, d); chk("R3 eighth match validates", d, 8'h54);
    rd(1'b1, d); chk("R3 ctrl after second validate", d, 8'h1B);
  endtask

  task automatic t_mode_off;
    logic [7:0] d;
    @(negedge clk); cbit_mode = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(1'b0, d); chk("R6 code cleared in idle", d, 8'h00);
    rd(1'b1, d); chk("R6 flags cleared enables kept", d, 8'h0A);
    chk("R6 irq low in idle", {7'd0, irq}, 8'h00);
    send(6'h2A);
    rd(1'b0, d); chk("R6 message ignored in idle", d, 8'h00);
    @(negedge clk); cbit_mode = 1'b1;
    send_n(6'h2A, 7);
    rd(1'b0, d); chk("R6 history flushed", d, 8'h00);
    send(6'h2A);
    rd(1'b0, d); chk("R6 validates after eight fresh", d, 8'h54);
    rd(1'b1, d);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    send(6'h01); send(6'h02);
    @(negedge clk); msg_valid = 1'b1; msg_code = 6'h03; reg_rd = 1'b1; reg_addr = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); msg_valid = 1'b0; reg_rd = 1'b0;
    chk("R8 read returns pre-edge value", d, 8'h1A);
    rd(1'b1, d); chk("R8 status set at read edge survives", d, 8'h0E);
    rd(1'b0, d); chk("R4 code cleared at collision", d, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; cbit_mode = 1'b1; msg_valid = 1'b0; msg_code = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_validate;
    t_remove;
    t_write_ignored;
    t_slide;
    t_mode_off;
    t_collision;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule